// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Controller

This block sits on the host side of a parallel NOR flash device. The host hands it one request at a time over a valid/ready handshake. A request is either a single-word program or an erase of a sector, a block or the whole chip. The block expands the request into the keyed series of bus write cycles the flash expects. Those cycles drive chip enable, write enable and output enable strobes, a 20-bit address and a 16-bit data bus. The spacing between strobe edges comes from parameterised clock counts.

Once the last write is issued, the block reads the target location over and over until the flash shows that its internal operation has finished. Two ways of seeing completion are supported. In data-poll mode, the block watches bit 7 of the status word for the true value of the written bit. In toggle mode, it compares bit 6 across two reads in a row. A poll limit guards against a flash that never finishes. In both cases the block reports a single done pulse, with a flag that says whether the result is a timeout.

Top module: `flash_pe_ctrl`

## Requirements
- R1: With `req_op` = 0 (program), the block issues exactly four writes, in this order: 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x00A0, then the request address with the full 16-bit request data.
- R2: With `req_op` = 1 (sector), 2 (block) or 3 (chip), the block issues six writes. The first five are 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x0080, 0x5555/0x00AA and 0x2AAA/0x0055, in that order.
- R3: The sixth erase write depends on the operation. Chip erase writes 0x5555/0x0010. Block erase writes the request address with 0x0050. Sector erase writes the request address with 0x0030.
- R4: Every keyed command write drives the upper data byte (bits 15:8) to zero.
- R5: On every write, chip enable goes low exactly T_SETUP clocks before write enable falls. Write enable stays low for exactly T_PULSE clocks, and output enable stays high. The address and data stay valid, with chip enable still low, for exactly T_HOLD clocks after write enable rises.
- R6: Once the writes are done, the block performs status reads at the request address. During a read, output enable is low, write enable is high and the data bus is released (`fl_dq_oe` = 0).
- R7: With `req_poll_toggle` = 0, the operation completes on the first status read whose bit 7 equals the expected bit. For a program, the expected bit is bit 7 of the request data. For any erase, it is 1.
- R8: With `req_poll_toggle` = 1, the operation completes on the first status read whose bit 6 equals bit 6 of the read just before it. The first read never completes.
- R9: If POLL_LIMIT status reads finish without completion, the block stops polling and reports done with `done_timeout` = 1. Otherwise it reports `done_timeout` = 0.
- R10: `req_ready` is high only while the block is idle. Requests presented while an operation is in progress are ignored and change neither the bus cycles nor the result.
- R11: While reset is asserted and right after it, all three strobes are high, `fl_dq_oe` is 0, `req_ready` is 1 and `done_valid` is 0.
- R12: `done_valid` is a pulse exactly one clock long at the end of each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 20 | Target word, sector or block address |
| req_data | input | 16 | Word to program |
| req_poll_toggle | input | 1 | 0 data-poll completion, 1 toggle completion |
| done_valid | output | 1 | One-clock completion pulse |
| done_timeout | output | 1 | Qualifies done_valid: poll limit reached |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | 20 | Flash address |
| fl_dq_out | output | 16 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 16 | Data returned by the flash |

## Verification
The bench sweeps all four operations against both completion modes. A flash model stays busy for 0, 2, 4, 5 or 7 reads, so that each mode lands below, exactly at and beyond the poll limit. A block that counted one read too many or too few would report a false timeout, or finish one read late. A design that used bit 7 in toggle mode, or bit 6 in data-poll mode, would finish at the wrong read, because the model drives the unused bit misleadingly in each case. Each recorded write is compared with the keyed order, with the command upper byte and with the setup, pulse and hold clock counts. This catches swapped keys, the wrong final erase code or a short strobe. Requests pushed in mid-operation must leave the write log untouched.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int STEP_W = 3;
    localparam int DP_BIT = 7;
    localparam int TG_BIT = 6;

    typedef enum logic [1:0] {
        OP_PROGRAM = 2'd0,
        OP_SECTOR  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CHIP    = 2'd3
    } op_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_word_t;

    localparam logic [ADDR_W-1:0] KEY_HI = 20'h05555;
    localparam logic [ADDR_W-1:0] KEY_LO = 20'h02AAA;

    function automatic logic [DATA_W-1:0] cmd_byte(input logic [7:0] b);
        return {{(DATA_W-8){1'b0}}, b};
    endfunction

    function automatic logic [STEP_W-1:0] last_step(input op_e op);
        return (op == OP_PROGRAM) ? STEP_W'(3) : STEP_W'(5);
    endfunction

    function automatic bus_word_t seq_step(input op_e op,
                                           input logic [STEP_W-1:0] k,
                                           input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
        bus_word_t w;
        w.addr = KEY_HI;
        w.data = cmd_byte(8'hAA);
        if (op == OP_PROGRAM) begin
            case (k)
                3'd0:    begin w.addr = KEY_HI; w.data = cmd_byte(8'hAA); end
                3'd1:    begin w.addr = KEY_LO; w.data = cmd_byte(8'h55); end
                3'd2:    begin w.addr = KEY_HI; w.data = cmd_byte(8'hA0); end
                default: begin w.addr = a;      w.data = d;               end
            endcase
        end else begin
            case (k)
                3'd0:    begin w.addr = KEY_HI; w.data = cmd_byte(8'hAA); end
                3'd1:    begin w.addr = KEY_LO; w.data = cmd_byte(8'h55); end
                3'd2:    begin w.addr = KEY_HI; w.data = cmd_byte(8'h80); end
                3'd3:    begin w.addr = KEY_HI; w.data = cmd_byte(8'hAA); end
                3'd4:    begin w.addr = KEY_LO; w.data = cmd_byte(8'h55); end
                default: begin
                    unique case (op)
                        OP_CHIP:  begin w.addr = KEY_HI; w.data = cmd_byte(8'h10); end
                        OP_BLOCK: begin w.addr = a;      w.data = cmd_byte(8'h50); end
                        default:  begin w.addr = a;      w.data = cmd_byte(8'h30); end
                    endcase
                end
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/fpe_bus_cycle.sv
module fpe_bus_cycle
    import fpe_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 2,
    parameter int T_HOLD  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              cyc_done,
    output logic [DATA_W-1:0] rdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CW = $clog2(TMAX + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            rd_q     <= 1'b0;
            cyc_done <= 1'b0;
            rdata    <= '0;
            ce_n     <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            addr_out <= '0;
            dq_out   <= '0;
            dq_oe    <= 1'b0;
        end else begin
            cyc_done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph       <= PH_SETUP;
                        cnt      <= '0;
                        rd_q     <= is_read;
                        ce_n     <= 1'b0;
                        addr_out <= addr_in;
                        dq_out   <= is_read ? '0 : data_in;
                        dq_oe    <= ~is_read;
                    end
                end
                PH_SETUP: begin
                    if (cnt == CW'(T_SETUP - 1)) begin
                        ph  <= PH_PULSE;
                        cnt <= '0;
                        if (rd_q) oe_n <= 1'b0;
                        else      we_n <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (cnt == CW'(T_PULSE - 1)) begin
                        ph   <= PH_HOLD;
                        cnt  <= '0;
                        we_n <= 1'b1;
                        oe_n <= 1'b1;
                        if (rd_q) rdata <= dq_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(T_HOLD - 1)) begin
                        ph       <= PH_IDLE;
                        cnt      <= '0;
                        ce_n     <= 1'b1;
                        dq_oe    <= 1'b0;
                        cyc_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n);                                            // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));                                          // R6
    AST_ADDR_STABLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(addr_out) && $stable(dq_out))); // R5
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !dq_oe);                                           // R6

endmodule

// File: rtl/fpe_poll_judge.sv
module fpe_poll_judge
    import fpe_pkg::*;
(
    input  logic              toggle_mode,
    input  logic              have_prev,
    input  logic              prev_tg,
    input  logic              exp_bit,
    input  logic [DATA_W-1:0] rdata,
    output logic              complete
);

    always_comb begin
        if (toggle_mode) complete = have_prev && (prev_tg == rdata[TG_BIT]);
        else             complete = (rdata[DP_BIT] == exp_bit);
    end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import fpe_pkg::*;
#(
    parameter int T_SETUP    = 2,
    parameter int T_PULSE    = 2,
    parameter int T_HOLD     = 1,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_poll_toggle,
    output logic              done_valid,
    output logic              done_timeout,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_in
);

    localparam int PCW = $clog2(POLL_LIMIT + 1);

    typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAITW, S_POLL, S_WAITR} state_e;

    state_e            st;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              tog_q;
    logic [STEP_W-1:0] step_q;
    logic [PCW-1:0]    rd_cnt;
    logic              have_prev;
    logic              prev_tg;

    bus_word_t         cur_word;
    logic              cyc_start;
    logic              cyc_read;
    logic              cyc_done;
    logic [DATA_W-1:0] rdata;
    logic              exp_bit;
    logic              complete;
    logic [PCW-1:0]    rd_cnt_n;

    assign cur_word  = seq_step(op_q, step_q, addr_q, data_q);
    assign cyc_start = (st == S_CMD) || (st == S_POLL);
    assign cyc_read  = (st == S_POLL);
    assign exp_bit   = (op_q == OP_PROGRAM) ? data_q[DP_BIT] : 1'b1;
    assign rd_cnt_n  = rd_cnt + 1'b1;
    assign req_ready = (st == S_IDLE);

    fpe_bus_cycle #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD)
    ) i_cycle (
        .clk      (clk),
        .rst      (rst),
        .start    (cyc_start),
        .is_read  (cyc_read),
        .addr_in  (cyc_read ? addr_q : cur_word.addr),
        .data_in  (cur_word.data),
        .cyc_done (cyc_done),
        .rdata    (rdata),
        .ce_n     (fl_ce_n),
        .we_n     (fl_we_n),
        .oe_n     (fl_oe_n),
        .addr_out (fl_addr),
        .dq_out   (fl_dq_out),
        .dq_oe    (fl_dq_oe),
        .dq_in    (fl_dq_in)
    );

    fpe_poll_judge i_judge (
        .toggle_mode (tog_q),
        .have_prev   (have_prev),
        .prev_tg     (prev_tg),
        .exp_bit     (exp_bit),
        .rdata       (rdata),
        .complete    (complete)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            op_q         <= OP_PROGRAM;
            addr_q       <= '0;
            data_q       <= '0;
            tog_q        <= 1'b0;
            step_q       <= '0;
            rd_cnt       <= '0;
            have_prev    <= 1'b0;
            prev_tg      <= 1'b0;
            done_valid   <= 1'b0;
            done_timeout <= 1'b0;
        end else begin
            done_valid   <= 1'b0;
            done_timeout <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q      <= op_e'(req_op);
                        addr_q    <= req_addr;
                        data_q    <= req_data;
                        tog_q     <= req_poll_toggle;
                        step_q    <= '0;
                        rd_cnt    <= '0;
                        have_prev <= 1'b0;
                        st        <= S_CMD;
                    end
                end
                S_CMD:  st <= S_WAITW;
                S_WAITW: begin
                    if (cyc_done) begin
                        if (step_q == last_step(op_q)) begin
                            st <= S_POLL;
                        end else begin
                            step_q <= step_q + 1'b1;
                            st     <= S_CMD;
                        end
                    end
                end
                S_POLL: st <= S_WAITR;
                default: begin
                    if (cyc_done) begin
                        prev_tg   <= rdata[TG_BIT];
                        have_prev <= 1'b1;
                        rd_cnt    <= rd_cnt_n;
                        if (complete) begin
                            done_valid <= 1'b1;
                            st         <= S_IDLE;
                        end else if (rd_cnt_n == PCW'(POLL_LIMIT)) begin
                            done_valid   <= 1'b1;
                            done_timeout <= 1'b1;
                            st           <= S_IDLE;
                        end else begin
                            st <= S_POLL;
                        end
                    end
                end
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);                                 // R12
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                    // R10
    AST_TIMEOUT_QUAL: assert property (@(posedge clk) disable iff (rst)
        done_timeout |-> done_valid);                                // R9
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        rd_cnt <= PCW'(POLL_LIMIT));                                 // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_ready && $past(req_ready)) |-> (fl_we_n && fl_oe_n));   // R10

endmodule

// File: tb/test_flash_pe_ctrl.sv
`timescale 1ns/1ps
module test_flash_pe_ctrl;

    localparam int TS = 2;
    localparam int TP = 3;
    localparam int TH = 1;
    localparam int PL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        req_poll_toggle = 1'b0;
    logic        done_valid, done_timeout;
    logic        fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [19:0] fl_addr;
    logic [15:0] fl_dq_out;
    logic [15:0] fl_dq_in;

    always #4 clk = ~clk;

    flash_pe_ctrl #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .POLL_LIMIT(PL)) i_flash_pe_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_poll_toggle(req_poll_toggle), .done_valid(done_valid),
        .done_timeout(done_timeout), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // flash model configuration, set by the stimulus process
    int          cfg_b = 0;
    logic        cfg_exp = 1'b1;
    logic        cfg_tog = 1'b0;
    logic [19:0] cfg_paddr = '0;
    int          rbase = 0;

    // monitor state
    logic [19:0] wr_addr [0:255];
    logic [15:0] wr_data [0:255];
    int          wr_cnt = 0;
    int          rd_idx = 0;
    int          setup_cnt = 0, we_cnt = 0, hold_cnt = 0;
    bit          hold_act = 0;
    logic        prev_we = 1'b1, prev_oe = 1'b1;
    logic [19:0] cap_addr;
    logic [15:0] cap_data;

    always_comb begin
        int rel;
        rel = rd_idx - rbase;
        fl_dq_in = 16'h0000;
        if (cfg_tog) begin
            fl_dq_in[7] = ~cfg_exp;
            fl_dq_in[6] = (rel < cfg_b) ? rel[0] : cfg_b[0];
        end else begin
            fl_dq_in[7] = (rel < cfg_b) ? ~cfg_exp : cfg_exp;
            fl_dq_in[6] = rel[0];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_we == 1'b0 && fl_we_n == 1'b1) begin
                chk(we_cnt == TP, "R5 we pulse width", we_cnt, TP);
                chk(setup_cnt == TS, "R5 ce setup before we", setup_cnt, TS);
                wr_addr[wr_cnt & 255] = cap_addr;
                wr_data[wr_cnt & 255] = cap_data;
                wr_cnt++;
                hold_act = 1;
                hold_cnt = 0;
            end
            if (prev_oe == 1'b0 && fl_oe_n == 1'b1) rd_idx++;
            if (fl_ce_n) begin
                if (hold_act) chk(hold_cnt == TH, "R5 hold after we", hold_cnt, TH);
                hold_act = 0;
                setup_cnt = 0;
            end else if (hold_act) begin
                hold_cnt++;
                chk(fl_addr == cap_addr && fl_dq_out == cap_data && fl_dq_oe,
                    "R5 addr/data held", fl_addr, cap_addr);
            end else if (fl_we_n && fl_oe_n) begin
                setup_cnt++;
            end
            if (!fl_we_n) begin
                we_cnt = (prev_we == 1'b0) ? we_cnt + 1 : 1;
                cap_addr = fl_addr;
                cap_data = fl_dq_out;
                chk(fl_oe_n && fl_dq_oe, "R5 oe high and bus driven during write", {fl_oe_n, fl_dq_oe}, 2'b11);
            end
            if (!fl_oe_n) begin
                chk(fl_we_n && !fl_dq_oe && fl_addr == cfg_paddr,
                    "R6 status read strobes/addr", fl_addr, cfg_paddr);
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    function automatic logic [35:0] exp_write(input int op, input int k,
                                              input logic [19:0] a, input logic [15:0] d);
        if (op == 0) begin
            case (k)
                0: return {20'h05555, 16'h00AA};
                1: return {20'h02AAA, 16'h0055};
                2: return {20'h05555, 16'h00A0};
                default: return {a, d};
            endcase
        end
        case (k)
            0: return {20'h05555, 16'h00AA};
            1: return {20'h02AAA, 16'h0055};
            2: return {20'h05555, 16'h0080};
            3: return {20'h05555, 16'h00AA};
            4: return {20'h02AAA, 16'h0055};
            default: begin
                if (op == 3) return {20'h05555, 16'h0010};
                if (op == 2) return {a, 16'h0050};
                return {a, 16'h0030};
            end
        endcase
    endfunction

    task automatic run_op(input int op, input bit tog, input int b);
        logic [19:0] a;
        logic [15:0] d;
        int wbase, nwr, need, exp_rd;
        bit exp_to;
        a = 20'(32'h1A000 + op * 32'h1111 + b * 7);
        d = 16'(32'hC35A ^ (b << 7) ^ (op << 9));
        cfg_b = b;
        cfg_tog = tog;
        cfg_exp = (op == 0) ? d[7] : 1'b1;
        cfg_paddr = a;
        rbase = rd_idx;
        wbase = wr_cnt;
        req_valid = 1'b1;
        req_op = 2'(op);
        req_addr = a;
        req_data = d;
        req_poll_toggle = tog;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
        // stray requests while busy must be ignored
        req_op = 2'(op ^ 1);
        req_addr = 20'hFFFFF;
        req_data = 16'h0F0F;
        req_poll_toggle = ~tog;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3000 && !done_valid; i++) @(negedge clk);
        nwr = (op == 0) ? 4 : 6;
        need = tog ? b + 2 : b + 1;
        exp_to = need > PL;
        exp_rd = exp_to ? PL : need;
        chk(done_valid == 1'b1, "R12 done reported", done_valid, 1);
        chk(done_timeout == exp_to, tog ? "R8/R9 timeout flag (toggle)" : "R7/R9 timeout flag (data)",
            done_timeout, exp_to);
        chk(rd_idx - rbase == exp_rd, tog ? "R8 status read count" : "R7 status read count",
            rd_idx - rbase, exp_rd);
        chk(wr_cnt - wbase == nwr, (op == 0) ? "R1 write count" : "R2 write count", wr_cnt - wbase, nwr);
        for (int k = 0; k < nwr && k < wr_cnt - wbase; k++) begin
            logic [35:0] e;
            e = exp_write(op, k, a, d);
            chk({wr_addr[(wbase + k) & 255], wr_data[(wbase + k) & 255]} == e,
                (op == 0) ? "R1 program write" : ((k == 5) ? "R3 final erase write" : "R2 erase key write"),
                {wr_addr[(wbase + k) & 255], wr_data[(wbase + k) & 255][11:0]}, {e[35:16], e[11:0]});
            if (!(op == 0 && k == 3))
                chk(wr_data[(wbase + k) & 255][15:8] == 8'h00, "R4 command upper byte zero",
                    wr_data[(wbase + k) & 255][15:8], 0);
        end
        @(negedge clk);
        chk(done_valid == 1'b0, "R12 done one clock", done_valid, 0);
        chk(req_ready == 1'b1, "R10 ready after done", req_ready, 1);
    endtask

    initial begin
        int bs [5];
        bs = '{0, 2, 4, 5, 7};
        repeat (4) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R11 strobes idle in reset",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
        chk(req_ready && !done_valid, "R11 ready/done in reset", {req_ready, done_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && req_ready && !done_valid, "R11 idle after reset",
            {fl_ce_n, fl_we_n, fl_oe_n, req_ready, done_valid}, 5'b11110);
        for (int op = 0; op < 4; op++)
            for (int t = 0; t < 2; t++)
                for (int j = 0; j < 5; j++)
                    run_op(op, t[0], bs[j]);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule